// File: doc/BRIEF.md
# Virtual-8086 Return Frame Unwinder

This block performs the return from a ring-0 handler to a task running in virtual-8086 mode. After a `start` pulse it takes the current stack pointer and first checks that the whole 36-byte return frame fits inside the stack segment limit. It then reads the saved flags image at an offset of 8 bytes and decides whether the return path applies. If it does, the block pops nine 4-byte slots through a simple request/acknowledge read port.

The popped values are held in shadow registers and nothing visible changes while the unwind runs. Once the last slot has arrived, the restored instruction pointer is checked against the code segment limit. If that check passes, the block loads the following in one clock cycle:

- all restored registers;
- the real-mode style segment bases, each being the selector times 16;
- the new privilege level 3.

If a check fails, the block raises a fault with a type and a 16-bit error code, and the architectural outputs stay as they were. If the flags image does not select virtual-8086 mode, or the caller is not at privilege 0, the block finishes with a "not taken" pulse and commits nothing.

Top module: `vm86_unwind`

## Requirements
- R1: After reset the block is idle: `busy`, `mem_req`, `done_commit`, `done_skip` and `fault` are 0, and `cpl_o` and all restored register and base outputs are 0.
- R2: If `esp_i + 35` exceeds `ss_limit_i`, or the sum carries past the address width, the block raises `fault` with `fault_kind` = 1 (stack) and `fault_err` = 0. It issues no memory read and commits nothing.
- R3: The first read goes to `esp_i + 8`. The restore path is taken only when bit 17 of that word is 1 and `cpl_i` is 0. Otherwise `done_skip` pulses after that single read, with no commit and no fault.
- R4: On the restore path the nine slots are read at `esp_i`, `esp_i+4`, …, `esp_i+32`, in this order: EIP, CS, flags (value dropped), ESP, SS, ES, DS, FS, GS.
- R5: For each selector slot only bits 15:0 are kept, and bits 31:16 are discarded.
- R6: If the popped EIP is greater than `cs_limit_i`, the block raises `fault` with `fault_kind` = 2 (general protection) and `fault_err` = 0, and commits nothing.
- R7: On success `done_commit` pulses. In that same cycle all restored outputs take their new values, `efl_o` equals the word read at `esp_i+8`, and `cpl_o` becomes 3.
- R8: Each segment base output equals its committed selector shifted left by 4 bits (20 bits wide).
- R9: `esp_o` is the popped ESP slot, not the walked stack pointer. The walked pointer equals `esp_i + 36` once all nine slots have been read.
- R10: A fault or a not-taken outcome leaves every restored output and `cpl_o` unchanged. Exactly one of commit, fault or not-taken ends each run.
- R11: While `mem_req` is high and `mem_ack` is low, `mem_req` stays high and `mem_addr` stays stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an unwind (accepted when idle) |
| esp_i | input | 32 | Stack pointer at the start of the return |
| cpl_i | input | 2 | Current privilege level, held while busy |
| ss_limit_i | input | 32 | Stack segment limit, held while busy |
| cs_limit_i | input | 32 | Code segment limit for the restored EIP, held while busy |
| mem_req | output | 1 | Read request |
| mem_addr | output | 32 | Read byte address |
| mem_ack | input | 1 | Read data valid; consumes the request |
| mem_rdata | input | 32 | Read data |
| busy | output | 1 | Unwind in progress |
| done_commit | output | 1 | One-cycle pulse: state committed |
| done_skip | output | 1 | One-cycle pulse: restore path not taken |
| fault | output | 1 | One-cycle pulse: check failed |
| fault_kind | output | 2 | 1 = stack fault, 2 = general protection |
| fault_err | output | 16 | Fault error code |
| cpl_o | output | 2 | Privilege level after the last commit |
| eip_o | output | 32 | Restored EIP |
| efl_o | output | 32 | Restored flags |
| esp_o | output | 32 | Restored ESP |
| cs_o | output | 16 | Restored CS selector |
| ss_o | output | 16 | Restored SS selector |
| es_o | output | 16 | Restored ES selector |
| ds_o | output | 16 | Restored DS selector |
| fs_o | output | 16 | Restored FS selector |
| gs_o | output | 16 | Restored GS selector |
| cs_base | output | 20 | CS base |
| ss_base | output | 20 | SS base |
| es_base | output | 20 | ES base |
| ds_base | output | 20 | DS base |
| fs_base | output | 20 | FS base |
| gs_base | output | 20 | GS base |

## Verification
The bench builds the block with its defaults: 32-bit addresses and data, 16-bit selectors, 4-byte slots and the mode flag at bit 17. With a 32-bit address, a stack pointer just below 2^32 makes the carry out of the frame-end sum reachable. With 16-bit selectors, the memory model can put distinct junk in the upper selector halves and show that it is dropped. The memory model answers with zero to three wait states, so request holding is exercised. Limits are placed exactly at the frame end and exactly at the popped EIP, so the boundary on each side of both checks is reached.

// File: rtl/vmr_pkg.sv
package vmr_pkg;

  // Slot order of the return frame; the order is behaviour.
  localparam int NSLOTS = 9;

  typedef enum logic [1:0] {SK_WIDE, SK_SEL, SK_DROP} slot_kind_e;
  typedef enum logic [1:0] {FLT_NONE = 2'd0, FLT_STACK = 2'd1, FLT_GP = 2'd2} fault_e;
  typedef enum logic [2:0] {ST_IDLE, ST_CHK, ST_FLG, ST_POP, ST_FIN} seq_state_e;

  // Slot 0 EIP, 1 CS, 2 flags (dropped), 3 ESP, 4 SS, 5 ES, 6 DS, 7 FS, 8 GS
  function automatic slot_kind_e slot_kind(input int i);
    case (i)
      0, 3:    return SK_WIDE;
      2:       return SK_DROP;
      default: return SK_SEL;
    endcase
  endfunction

  function automatic int count_kind(input slot_kind_e k);
    int n = 0;
    for (int j = 0; j < NSLOTS; j++) if (slot_kind(j) == k) n++;
    return n;
  endfunction

  // Rank of slot i among earlier slots of the same kind
  function automatic int kind_rank(input int i);
    int n = 0;
    for (int j = 0; j < i; j++) if (slot_kind(j) == slot_kind(i)) n++;
    return n;
  endfunction

  localparam int NWIDE = count_kind(SK_WIDE);
  localparam int NSEL  = count_kind(SK_SEL);

  localparam int W_EIP = 0;
  localparam int W_ESP = 1;
  localparam int S_CS  = 0;
  localparam int S_SS  = 1;
  localparam int S_ES  = 2;
  localparam int S_DS  = 3;
  localparam int S_FS  = 4;
  localparam int S_GS  = 5;

endpackage

// File: rtl/vmr_limits.sv
module vmr_limits #(
  parameter int AW          = 32,
  parameter int FRAME_BYTES = 36
) (
  input  logic [AW-1:0] esp,
  input  logic [AW-1:0] ss_lim,
  input  logic [AW-1:0] eip,
  input  logic [AW-1:0] cs_lim,
  output logic          stack_ok,
  output logic          eip_ok
);

  // Last byte of the frame, computed one bit wider so a wrap shows as a miss.
  function automatic logic frame_fits(input logic [AW-1:0] base, input logic [AW-1:0] lim);
    logic [AW:0] last;
    last = {1'b0, base} + (AW+1)'(FRAME_BYTES - 1);
    return last <= {1'b0, lim};
  endfunction

  function automatic logic ip_inside(input logic [AW-1:0] ip, input logic [AW-1:0] lim);
    return ip <= lim;
  endfunction

  assign stack_ok = frame_fits(esp, ss_lim);
  assign eip_ok   = ip_inside(eip, cs_lim);

endmodule

// File: rtl/vmr_shadow.sv
module vmr_shadow
  import vmr_pkg::*;
#(
  parameter int DW    = 32,
  parameter int SEL_W = 16,
  parameter int IDX_W = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en,
  input  logic [IDX_W-1:0]            wr_idx,
  input  logic [DW-1:0]               wr_data,
  output logic [NWIDE-1:0][DW-1:0]    wide_q,
  output logic [NSEL-1:0][SEL_W-1:0]  sel_q
);

  for (genvar g = 0; g < NSLOTS; g++) begin : g_slot
    if (slot_kind(g) == SK_WIDE) begin : g_wide
      logic [DW-1:0] r;
      always_ff @(posedge clk) begin
        if (!rst_n)                                   r <= '0;
        else if (wr_en && wr_idx == IDX_W'(g))        r <= wr_data;
      end
      assign wide_q[kind_rank(g)] = r;
    end else if (slot_kind(g) == SK_SEL) begin : g_sel
      logic [SEL_W-1:0] r;
      always_ff @(posedge clk) begin
        if (!rst_n)                                   r <= '0;
        else if (wr_en && wr_idx == IDX_W'(g))        r <= wr_data[SEL_W-1:0];
      end
      assign sel_q[kind_rank(g)] = r;
    end
  end

endmodule

// File: rtl/vmr_seq.sv
module vmr_seq
  import vmr_pkg::*;
#(
  parameter int AW         = 32,
  parameter int SLOT_BYTES = 4,
  parameter int EFL_OFS    = 8,
  parameter int VM_BIT     = 17,
  parameter int IDX_W      = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [AW-1:0]    esp_i,
  input  logic [1:0]       cpl_i,
  input  logic             stack_ok,
  input  logic             eip_ok,
  input  logic             mem_ack,
  input  logic [AW-1:0]    mem_rdata,
  output logic             mem_req,
  output logic [AW-1:0]    mem_addr,
  output logic             shd_we,
  output logic [IDX_W-1:0] shd_idx,
  output logic [AW-1:0]    flags_q,
  output logic [AW-1:0]    esp0_q,
  output logic [AW-1:0]    wsp_q,
  output logic             in_fin,
  output logic             fire_commit,
  output logic             fire_stack_flt,
  output logic             fire_gp_flt,
  output logic             fire_skip,
  output logic             busy
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NSLOTS - 1);

  seq_state_e state_q;
  logic [IDX_W-1:0] idx_q;

  function automatic logic v86_entry(input logic [AW-1:0] img, input logic [1:0] cpl);
    return img[VM_BIT] && (cpl == 2'd0);
  endfunction

  function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
    return p + AW'(SLOT_BYTES);
  endfunction

  always_comb begin
    mem_req        = 1'b0;
    mem_addr       = wsp_q;
    shd_we         = 1'b0;
    fire_commit    = 1'b0;
    fire_stack_flt = 1'b0;
    fire_gp_flt    = 1'b0;
    fire_skip      = 1'b0;
    case (state_q)
      ST_CHK: fire_stack_flt = !stack_ok;
      ST_FLG: begin
        mem_req   = 1'b1;
        mem_addr  = esp0_q + AW'(EFL_OFS);
        fire_skip = mem_ack && !v86_entry(mem_rdata, cpl_i);
      end
      ST_POP: begin
        mem_req = 1'b1;
        shd_we  = mem_ack;
      end
      ST_FIN: begin
        fire_commit = eip_ok;
        fire_gp_flt = !eip_ok;
      end
      default: ;
    endcase
  end

  assign shd_idx = idx_q;
  assign in_fin  = (state_q == ST_FIN);
  assign busy    = (state_q != ST_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      flags_q <= '0;
      esp0_q  <= '0;
      wsp_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start) begin
          esp0_q  <= esp_i;
          wsp_q   <= esp_i;
          idx_q   <= '0;
          state_q <= ST_CHK;
        end
        ST_CHK: state_q <= stack_ok ? ST_FLG : ST_IDLE;
        ST_FLG: if (mem_ack) begin
          flags_q <= mem_rdata;
          state_q <= v86_entry(mem_rdata, cpl_i) ? ST_POP : ST_IDLE;
        end
        ST_POP: if (mem_ack) begin
          wsp_q <= step(wsp_q);
          idx_q <= idx_q + 1'b1;
          if (idx_q == LAST_IDX) state_q <= ST_FIN;
        end
        ST_FIN: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/vm86_unwind.sv
module vm86_unwind
  import vmr_pkg::*;
#(
  parameter int AW         = 32,
  parameter int SEL_W      = 16,
  parameter int SLOT_BYTES = 4,
  parameter int EFL_OFS    = 8,
  parameter int VM_BIT     = 17,
  parameter int NEW_CPL    = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [AW-1:0]       esp_i,
  input  logic [1:0]          cpl_i,
  input  logic [AW-1:0]       ss_limit_i,
  input  logic [AW-1:0]       cs_limit_i,
  output logic                mem_req,
  output logic [AW-1:0]       mem_addr,
  input  logic                mem_ack,
  input  logic [AW-1:0]       mem_rdata,
  output logic                busy,
  output logic                done_commit,
  output logic                done_skip,
  output logic                fault,
  output logic [1:0]          fault_kind,
  output logic [15:0]         fault_err,
  output logic [1:0]          cpl_o,
  output logic [AW-1:0]       eip_o,
  output logic [AW-1:0]       efl_o,
  output logic [AW-1:0]       esp_o,
  output logic [SEL_W-1:0]    cs_o,
  output logic [SEL_W-1:0]    ss_o,
  output logic [SEL_W-1:0]    es_o,
  output logic [SEL_W-1:0]    ds_o,
  output logic [SEL_W-1:0]    fs_o,
  output logic [SEL_W-1:0]    gs_o,
  output logic [SEL_W+3:0]    cs_base,
  output logic [SEL_W+3:0]    ss_base,
  output logic [SEL_W+3:0]    es_base,
  output logic [SEL_W+3:0]    ds_base,
  output logic [SEL_W+3:0]    fs_base,
  output logic [SEL_W+3:0]    gs_base
);

  localparam int FRAME_BYTES = NSLOTS * SLOT_BYTES;
  localparam int IDX_W       = $clog2(NSLOTS);
  localparam int BASE_W      = SEL_W + 4;
  localparam logic [15:0] ERR_NULL = 16'h0000;

  function automatic logic [BASE_W-1:0] seg_base(input logic [SEL_W-1:0] sel);
    return {sel, 4'b0000};
  endfunction

  // Named internal events (also observed by the bound checker)
  logic             stack_ok, eip_ok, in_fin, shd_we;
  logic             fire_commit, fire_stack_flt, fire_gp_flt, fire_skip;
  logic [IDX_W-1:0] shd_idx;
  logic [AW-1:0]    flags_q, esp0_q, wsp_q;
  logic [NWIDE-1:0][AW-1:0]   wide_q;
  logic [NSEL-1:0][SEL_W-1:0] sel_q;

  logic [NSEL-1:0][SEL_W-1:0]  seg_q;
  logic [NSEL-1:0][BASE_W-1:0] base_q;

  vmr_seq #(
    .AW(AW), .SLOT_BYTES(SLOT_BYTES), .EFL_OFS(EFL_OFS), .VM_BIT(VM_BIT), .IDX_W(IDX_W)
  ) seq_i (
    .clk(clk), .rst_n(rst_n), .start(start), .esp_i(esp_i), .cpl_i(cpl_i),
    .stack_ok(stack_ok), .eip_ok(eip_ok), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .mem_req(mem_req), .mem_addr(mem_addr), .shd_we(shd_we), .shd_idx(shd_idx),
    .flags_q(flags_q), .esp0_q(esp0_q), .wsp_q(wsp_q), .in_fin(in_fin),
    .fire_commit(fire_commit), .fire_stack_flt(fire_stack_flt),
    .fire_gp_flt(fire_gp_flt), .fire_skip(fire_skip), .busy(busy)
  );

  vmr_shadow #(.DW(AW), .SEL_W(SEL_W), .IDX_W(IDX_W)) shadow_i (
    .clk(clk), .rst_n(rst_n), .wr_en(shd_we), .wr_idx(shd_idx), .wr_data(mem_rdata),
    .wide_q(wide_q), .sel_q(sel_q)
  );

  vmr_limits #(.AW(AW), .FRAME_BYTES(FRAME_BYTES)) limits_i (
    .esp(esp0_q), .ss_lim(ss_limit_i), .eip(wide_q[W_EIP]), .cs_lim(cs_limit_i),
    .stack_ok(stack_ok), .eip_ok(eip_ok)
  );

  // Architectural bank: loaded in a single cycle, only on a clean finish.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cpl_o  <= 2'd0;
      eip_o  <= '0;
      efl_o  <= '0;
      esp_o  <= '0;
      seg_q  <= '0;
      base_q <= '0;
    end else if (fire_commit) begin
      cpl_o <= 2'(NEW_CPL);
      eip_o <= wide_q[W_EIP];
      esp_o <= wide_q[W_ESP];
      efl_o <= flags_q;
      for (int s = 0; s < NSEL; s++) begin
        seg_q[s]  <= sel_q[s];
        base_q[s] <= seg_base(sel_q[s]);
      end
    end
  end

  // Outcome pulses
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done_commit <= 1'b0;
      done_skip   <= 1'b0;
      fault       <= 1'b0;
      fault_kind  <= FLT_NONE;
      fault_err   <= ERR_NULL;
    end else begin
      done_commit <= fire_commit;
      done_skip   <= fire_skip;
      fault       <= fire_stack_flt | fire_gp_flt;
      if (fire_stack_flt)                fault_kind <= FLT_STACK;
      else if (fire_gp_flt)              fault_kind <= FLT_GP;
      else if (fire_commit || fire_skip) fault_kind <= FLT_NONE;
      if (fire_stack_flt || fire_gp_flt) fault_err <= ERR_NULL;
    end
  end

  assign cs_o = seg_q[S_CS];
  assign ss_o = seg_q[S_SS];
  assign es_o = seg_q[S_ES];
  assign ds_o = seg_q[S_DS];
  assign fs_o = seg_q[S_FS];
  assign gs_o = seg_q[S_GS];
  assign cs_base = base_q[S_CS];
  assign ss_base = base_q[S_SS];
  assign es_base = base_q[S_ES];
  assign ds_base = base_q[S_DS];
  assign fs_base = base_q[S_FS];
  assign gs_base = base_q[S_GS];

endmodule

// File: rtl/vmr_chk.sv
module vmr_chk #(
  parameter int AW          = 32,
  parameter int SEL_W       = 16,
  parameter int FRAME_BYTES = 36,
  parameter int VM_BIT      = 17,
  parameter int NEW_CPL     = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             mem_req,
  input logic             mem_ack,
  input logic [AW-1:0]    mem_addr,
  input logic             in_fin,
  input logic [AW-1:0]    esp0_q,
  input logic [AW-1:0]    wsp_q,
  input logic             fire_commit,
  input logic             fire_stack_flt,
  input logic             fire_gp_flt,
  input logic             fire_skip,
  input logic             fault,
  input logic [1:0]       fault_kind,
  input logic             done_commit,
  input logic [1:0]       cpl_o,
  input logic [AW-1:0]    eip_o,
  input logic [AW-1:0]    esp_o,
  input logic [AW-1:0]    efl_o,
  input logic [SEL_W-1:0] cs_o,
  input logic [SEL_W+3:0] cs_base,
  input logic [SEL_W-1:0] gs_o,
  input logic [SEL_W+3:0] gs_base,
  input logic [AW-1:0]    cs_limit_i
);

  assert_stack_fault_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fire_stack_flt |=> fault && fault_kind == 2'd1 && !mem_req);

  assert_vm_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done_commit |-> efl_o[VM_BIT]);

  assert_eip_limit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done_commit |-> eip_o <= cs_limit_i);

  assert_gp_kind_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fire_gp_flt |=> fault && fault_kind == 2'd2);

  assert_commit_cpl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done_commit |-> cpl_o == 2'(NEW_CPL));

  assert_base_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_commit |-> cs_base == {cs_o, 4'b0000} && gs_base == {gs_o, 4'b0000});

  assert_walk_end_R9: assert property (@(posedge clk) disable iff (!rst_n)
    in_fin |-> wsp_q == esp0_q + AW'(FRAME_BYTES));

  assert_one_outcome_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({fire_commit, fire_stack_flt, fire_gp_flt, fire_skip}));

  assert_fault_keeps_R10: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> $stable(eip_o) && $stable(esp_o) && $stable(cpl_o) && $stable(cs_o));

  assert_req_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr));

endmodule

bind vm86_unwind vmr_chk #(
  .AW(AW), .SEL_W(SEL_W), .FRAME_BYTES(FRAME_BYTES), .VM_BIT(VM_BIT), .NEW_CPL(NEW_CPL)
) chk_i (
  .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_ack(mem_ack), .mem_addr(mem_addr),
  .in_fin(in_fin), .esp0_q(esp0_q), .wsp_q(wsp_q),
  .fire_commit(fire_commit), .fire_stack_flt(fire_stack_flt),
  .fire_gp_flt(fire_gp_flt), .fire_skip(fire_skip),
  .fault(fault), .fault_kind(fault_kind), .done_commit(done_commit), .cpl_o(cpl_o),
  .eip_o(eip_o), .esp_o(esp_o), .efl_o(efl_o), .cs_o(cs_o), .cs_base(cs_base),
  .gs_o(gs_o), .gs_base(gs_base), .cs_limit_i(cs_limit_i)
);

// File: tb/vm86_unwind_tb.sv
`timescale 1ns/1ps
module vm86_unwind_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] esp_i = '0, ss_limit_i = '0, cs_limit_i = '0;
  logic [1:0]  cpl_i = '0;
  logic        mem_req, mem_ack = 1'b0;
  logic [31:0] mem_addr, mem_rdata = '0;
  logic        busy, done_commit, done_skip, fault;
  logic [1:0]  fault_kind, cpl_o;
  logic [15:0] fault_err;
  logic [31:0] eip_o, efl_o, esp_o;
  logic [15:0] cs_o, ss_o, es_o, ds_o, fs_o, gs_o;
  logic [19:0] cs_base, ss_base, es_base, ds_base, fs_base, gs_base;

  always #4 clk = ~clk;

  vm86_unwind dut_i (.*);

  int n_chk = 0, n_bad = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Memory model state
  logic [31:0] fr_base = '0, fr_eip = '0;
  logic        fr_vm = 1'b0;
  int          cur_ws = 0, wcnt = 0, nlog = 0;
  logic [31:0] rlog [16];
  logic        hold_err = 1'b0;
  logic [31:0] wait_addr = '0;

  function automatic logic [15:0] sel_val(input int slot, input logic [31:0] b);
    return 16'(16'h0A00 + slot * 16'h0111) ^ b[15:0];
  endfunction

  function automatic logic [31:0] flag_val(input logic vm);
    return vm ? 32'h0002_0202 : 32'h0000_0202;
  endfunction

  function automatic logic [31:0] slot_word(input int s);
    case (s)
      0: return fr_eip;
      2: return flag_val(fr_vm);
      3: return 32'h0001_FF00 ^ fr_base;
      default: return {16'(16'hBAD0 + s), sel_val(s, fr_base)};
    endcase
  endfunction

  function automatic logic [31:0] mem_word(input logic [31:0] a);
    logic [32:0] off = {1'b0, a} - {1'b0, fr_base};
    if (a >= fr_base && off < 33'd36 && a[1:0] == 2'b00) return slot_word(int'(off[5:2]));
    return 32'hDEAD_BEEF;
  endfunction

  always @(negedge clk) begin
    if (!rst_n || !mem_req) begin
      mem_ack = 1'b0; wcnt = 0;
    end else if (wcnt >= cur_ws) begin
      if (wcnt > 0 && mem_addr !== wait_addr) hold_err = 1'b1;
      mem_ack = 1'b1; mem_rdata = mem_word(mem_addr);
      if (nlog < 16) rlog[nlog] = mem_addr;
      nlog++; wcnt = 0;
    end else begin
      if (wcnt > 0 && mem_addr !== wait_addr) hold_err = 1'b1;
      wait_addr = mem_addr; mem_ack = 1'b0; wcnt++;
    end
  end

  // Expected architectural state
  logic [31:0] m_eip = '0, m_esp = '0, m_efl = '0;
  logic [1:0]  m_cpl = '0;
  logic [15:0] m_sel [6] = '{default: '0};

  task automatic model_reset();
    m_eip = '0; m_esp = '0; m_efl = '0; m_cpl = '0;
    for (int k = 0; k < 6; k++) m_sel[k] = '0;
  endtask

  task automatic check_arch(input string tag);
    chk({tag, " eip"}, eip_o, m_eip);
    chk({tag, " esp"}, esp_o, m_esp);
    chk({tag, " efl"}, efl_o, m_efl);
    chk({tag, " cpl"}, 32'(cpl_o), 32'(m_cpl));
    chk({tag, " cs"}, 32'(cs_o), 32'(m_sel[0]));
    chk({tag, " ss"}, 32'(ss_o), 32'(m_sel[1]));
    chk({tag, " es"}, 32'(es_o), 32'(m_sel[2]));
    chk({tag, " ds"}, 32'(ds_o), 32'(m_sel[3]));
    chk({tag, " fs"}, 32'(fs_o), 32'(m_sel[4]));
    chk({tag, " gs"}, 32'(gs_o), 32'(m_sel[5]));
  endtask

  typedef struct packed {
    logic [31:0] esp;
    logic [31:0] sslim;
    logic [31:0] cslim;
    logic [31:0] eip;
    logic [1:0]  cpl;
    logic        vm;
    logic [1:0]  ws;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VEC [NV] = '{
    '{32'h0000_1000, 32'h0000_FFFF, 32'h0000_FFFF, 32'h0000_0100, 2'd0, 1'b1, 2'd0},
    '{32'h0000_2000, 32'h0000_FFFF, 32'h0000_FFFF, 32'h0000_FFFF, 2'd0, 1'b1, 2'd2},
    '{32'h0000_FFDC, 32'h0000_FFFF, 32'h0000_FFFF, 32'h0000_0042, 2'd0, 1'b1, 2'd1},
    '{32'h0000_FFDD, 32'h0000_FFFF, 32'h0000_FFFF, 32'h0000_0042, 2'd0, 1'b1, 2'd0},
    '{32'hFFFF_FFF0, 32'hFFFF_FFFF, 32'h0000_FFFF, 32'h0000_0042, 2'd0, 1'b1, 2'd0},
    '{32'h0000_3000, 32'h0000_FFFF, 32'h0000_FFFF, 32'h0000_0042, 2'd0, 1'b0, 2'd1},
    '{32'h0000_3000, 32'h0000_FFFF, 32'h0000_FFFF, 32'h0000_0042, 2'd3, 1'b1, 2'd0},
    '{32'h0000_4000, 32'h0000_FFFF, 32'h0000_FFFF, 32'h0001_0000, 2'd0, 1'b1, 2'd0},
    '{32'h0000_0800, 32'h000F_FFFF, 32'h0000_FFFF, 32'h0000_1234, 2'd0, 1'b1, 2'd3}
  };

  task automatic launch(input vec_t v);
    @(negedge clk);
    esp_i = v.esp; ss_limit_i = v.sslim; cs_limit_i = v.cslim; cpl_i = v.cpl;
    fr_base = v.esp; fr_eip = v.eip; fr_vm = v.vm; cur_ws = int'(v.ws);
    nlog = 0; hold_err = 1'b0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic run_vec(input vec_t v);
    int outc, nexp, cnt;
    logic got;
    logic [32:0] last;
    launch(v);
    got = 1'b0; cnt = 0;
    while (!got && cnt < 400) begin
      if (done_commit || done_skip || fault) got = 1'b1;
      else begin @(negedge clk); cnt++; end
    end
    if (!got) begin chk("R10 no outcome", 32'd0, 32'd1); return; end

    last = {1'b0, v.esp} + 33'd35;
    if (last > {1'b0, v.sslim})            begin outc = 1; nexp = 0;  end
    else if (!v.vm || v.cpl != 2'd0)        begin outc = 3; nexp = 1;  end
    else if (v.eip > v.cslim)               begin outc = 2; nexp = 10; end
    else                                    begin outc = 0; nexp = 10; end

    chk("R10 single outcome", 32'({done_commit, done_skip, fault}),
        32'(outc == 0 ? 3'b100 : outc == 3 ? 3'b010 : 3'b001));
    chk("R4 read count", 32'(nlog), 32'(nexp));
    for (int i = 0; i < nexp && i < nlog; i++)
      chk(i == 0 ? "R3 flags read addr" : "R4 pop addr", rlog[i],
          i == 0 ? v.esp + 32'd8 : v.esp + 32'(4 * (i - 1)));
    chk("R11 request held", 32'(hold_err), 32'd0);

    if (outc == 1 || outc == 2) begin
      chk(outc == 1 ? "R2 fault kind" : "R6 fault kind", 32'(fault_kind), 32'(outc));
      chk(outc == 1 ? "R2 fault err" : "R6 fault err", 32'(fault_err), 32'd0);
    end
    if (outc == 0) begin
      m_eip = v.eip; m_esp = 32'h0001_FF00 ^ v.esp; m_efl = flag_val(1'b1); m_cpl = 2'd3;
      m_sel[0] = sel_val(1, v.esp); m_sel[1] = sel_val(4, v.esp); m_sel[2] = sel_val(5, v.esp);
      m_sel[3] = sel_val(6, v.esp); m_sel[4] = sel_val(7, v.esp); m_sel[5] = sel_val(8, v.esp);
      check_arch("R7 R5 R9 commit");
      chk("R8 cs base", 32'(cs_base), {12'h0, m_sel[0], 4'h0});
      chk("R8 ss base", 32'(ss_base), {12'h0, m_sel[1], 4'h0});
      chk("R8 es base", 32'(es_base), {12'h0, m_sel[2], 4'h0});
      chk("R8 ds base", 32'(ds_base), {12'h0, m_sel[3], 4'h0});
      chk("R8 fs base", 32'(fs_base), {12'h0, m_sel[4], 4'h0});
      chk("R8 gs base", 32'(gs_base), {12'h0, m_sel[5], 4'h0});
    end else begin
      check_arch("R10 unchanged");
    end
    @(negedge clk);
  endtask

  initial begin
    #(8 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired: actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 busy", 32'(busy), 32'd0);
    chk("R1 mem_req", 32'(mem_req), 32'd0);
    chk("R1 pulses", 32'({done_commit, done_skip, fault}), 32'd0);
    check_arch("R1 reset");
    chk("R1 cs base", 32'(cs_base), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) run_vec(VEC[i]);

    // Reset in the middle of the pops returns to the reset state (R1)
    launch(VEC[8]);
    repeat (6) @(negedge clk);
    chk("R1 busy before reset", 32'(busy), 32'd1);
    rst_n = 1'b0;
    @(negedge clk);
    model_reset();
    chk("R1 busy after reset", 32'(busy), 32'd0);
    chk("R1 mem_req after reset", 32'(mem_req), 32'd0);
    check_arch("R1 mid-run reset");
    rst_n = 1'b1;
    @(negedge clk);
    run_vec(VEC[1]);
    // A later stack fault keeps the state of that commit
    run_vec(VEC[3]);

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule